// File: doc/BRIEF.md
# Flash Security Lock Controller

This block decides, cycle by cycle, whether a request that touches the on-chip flash may proceed. When reset ends, it takes one sample of the protection byte that sits at the highest flash address (0BFFFH), decodes it and holds the result as a lock state. Later changes to that byte have no effect until the next reset. A completed whole-array erase is the only event that clears the lock without a reset.

The lock state gates three request paths. The first is instruction-space reads of flash. The second is writes to the 4-bit command field of the flash control register. The third is requests from the parallel programming port. Each request comes with a code-origin tag or an operation code. For each path the block returns a combinational grant.

The decode is fault tolerant. Only the two erased-looking values 00H and FFH unlock. The arming value 50H and every other pattern, including any single-bit corruption of 50H, keep the lock on.

Top module: `fsec_lock_ctrl`

## Requirements
- R1: While `rst_n` is low, and in the cycle after it rises until the first clock edge, `lock_active_o` is 1 and restricted requests are denied.
- R2: At the first rising clock edge with `rst_n` high, the lock takes the decode of `sec_byte_i`. 50H gives active (1) and 00H or FFH give inactive (0). The new value is visible after that edge.
- R3: Any sampled byte other than 00H or FFH yields an active lock (for example 51H, D0H, 40H).
- R4: After the sampling edge, changes on `sec_byte_i` never change `lock_active_o` until the next reset.
- R5: `code_rd_ok_o` equals `code_rd_req_i` when the lock is inactive or `origin_i` is internal (00) or boot (10). It is 0 when the lock is active and `origin_i` is external (01) or reserved (11).
- R6: With `origin_i` internal (00), `cmd_wr_ok_o` follows `cmd_wr_i` whatever the lock state.
- R7: With the lock active and `origin_i` not internal, `cmd_wr_ok_o` is 1 only when `cmd_wr_i` is 1 and `cmd_val_i` equals the whole-erase command (default 3H).
- R8: `par_op_i` is encoded as 00 whole erase, 01 program, 10 verify, 11 signature read. With the lock active, program and verify are denied and whole erase and signature read are granted. With the lock inactive, all four are granted when `par_req_i` is 1.
- R9: A 1 on `erase_done_i` clears the lock at the next clock edge. This includes a pulse in the sampling cycle, where the clear wins over the sample.
- R10: No grant output is 1 while its own request input is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sec_byte_i | input | 8 | Protection byte read from the top flash address |
| erase_done_i | input | 1 | Pulse: whole-array erase finished |
| origin_i | input | 2 | Origin of the requesting code: 00 internal, 01 external, 10 boot, 11 reserved |
| code_rd_req_i | input | 1 | Instruction-space read of flash requested |
| cmd_wr_i | input | 1 | Write to the flash command field requested |
| cmd_val_i | input | 4 | Command value being written |
| par_req_i | input | 1 | Parallel-port operation requested |
| par_op_i | input | 2 | Parallel operation code |
| code_rd_ok_o | output | 1 | Instruction-space read granted |
| cmd_wr_ok_o | output | 1 | Command write granted |
| par_ok_o | output | 1 | Parallel operation granted |
| lock_active_o | output | 1 | Current lock state |

## Verification
The hardest state to reach is the single sampling cycle just after reset release. This is where the byte decode, the pending flag and a possible erase-done pulse all meet. Ordinary traffic never returns the block there. The stimulus therefore re-enters reset many times with directed byte values, including single-bit corruptions of 50H. It also aims an erase-done pulse at that exact edge, and then runs random request traffic between resets while the protection byte keeps changing.

// File: rtl/fsec_pkg.sv
package fsec_pkg;
   typedef logic [1:0] origin_t;
   localparam origin_t ORG_INT  = 2'b00;
   localparam origin_t ORG_EXT  = 2'b01;
   localparam origin_t ORG_BOOT = 2'b10;
   localparam origin_t ORG_RSVD = 2'b11;

   typedef logic [1:0] par_op_t;
   localparam par_op_t POP_ERASE = 2'b00;
   localparam par_op_t POP_PROG  = 2'b01;
   localparam par_op_t POP_VERF  = 2'b10;
   localparam par_op_t POP_SIG   = 2'b11;
endpackage

// File: rtl/fsec_code_decode.sv
module fsec_code_decode #(
   parameter int          BYTE_W      = 8,
   parameter logic [BYTE_W-1:0] LOCK_CODE   = 8'h50,
   parameter logic [BYTE_W-1:0] OPEN_CODE_A = 8'h00,
   parameter logic [BYTE_W-1:0] OPEN_CODE_B = 8'hFF,
   parameter bit          FAIL_SAFE   = 1'b1
) (
   input  logic [BYTE_W-1:0] byte_i,
   output logic              active_o
);
   logic is_open;
   logic is_lock;

   assign is_open = (byte_i == OPEN_CODE_A) || (byte_i == OPEN_CODE_B);
   assign is_lock = (byte_i == LOCK_CODE);

   generate
      if (FAIL_SAFE) begin : g_fail_safe
         // everything not explicitly open stays locked
         assign active_o = is_lock || !is_open;
      end else begin : g_exact
         assign active_o = is_lock && !is_open;
      end
   endgenerate
endmodule

// File: rtl/fsec_lock_reg.sv
module fsec_lock_reg (
   input  logic clk,
   input  logic rst_n,
   input  logic active_code_i,
   input  logic erase_done_i,
   output logic locked_o
);
   logic pend_q;
   logic lock_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q <= 1'b1;
         lock_q <= 1'b1;
      end else if (erase_done_i) begin
         pend_q <= 1'b0;
         lock_q <= 1'b0;
      end else if (pend_q) begin
         pend_q <= 1'b0;
         lock_q <= active_code_i;
      end
   end

   assign locked_o = lock_q;

   assert_pending_locked_R1: assert property (@(posedge clk) disable iff (!rst_n)
      pend_q |-> lock_q);
   assert_sample_taken_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_q && !erase_done_i) |=> (lock_q == $past(active_code_i)));
   assert_lock_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!pend_q && !erase_done_i) |=> $stable(lock_q));
   assert_erase_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
      erase_done_i |=> !lock_q);
endmodule

// File: rtl/fsec_access_gate.sv
module fsec_access_gate
   import fsec_pkg::*;
#(
   parameter int             CMD_W         = 4,
   parameter logic [CMD_W-1:0] ERASE_ALL_CMD = 4'h3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             locked_i,
   input  origin_t          origin_i,
   input  logic             code_rd_req_i,
   input  logic             cmd_wr_i,
   input  logic [CMD_W-1:0] cmd_val_i,
   input  logic             par_req_i,
   input  par_op_t          par_op_i,
   output logic             code_rd_ok_o,
   output logic             cmd_wr_ok_o,
   output logic             par_ok_o
);
   logic trusted_fetch;
   logic trusted_cmd;
   logic erase_cmd;
   logic par_allowed;

   assign trusted_fetch = (origin_i == ORG_INT) || (origin_i == ORG_BOOT);
   assign trusted_cmd   = (origin_i == ORG_INT);
   assign erase_cmd     = (cmd_val_i == ERASE_ALL_CMD);
   assign par_allowed   = (par_op_i == POP_ERASE) || (par_op_i == POP_SIG);

   always_comb begin
      code_rd_ok_o = code_rd_req_i && (!locked_i || trusted_fetch);
      cmd_wr_ok_o  = cmd_wr_i && (!locked_i || trusted_cmd || erase_cmd);
      par_ok_o     = par_req_i && (!locked_i || par_allowed);
   end

   assert_ext_read_blocked_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (locked_i && (origin_i == ORG_EXT)) |-> !code_rd_ok_o);
   assert_internal_free_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_wr_i && (origin_i == ORG_INT)) |-> cmd_wr_ok_o);
   assert_prog_blocked_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (locked_i && (par_op_i == POP_PROG || par_op_i == POP_VERF)) |-> !par_ok_o);
   assert_no_spurious_grant_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $countones({code_rd_ok_o && !code_rd_req_i, cmd_wr_ok_o && !cmd_wr_i,
                  par_ok_o && !par_req_i}) == 0);
endmodule

// File: rtl/fsec_lock_ctrl.sv
module fsec_lock_ctrl
   import fsec_pkg::*;
#(
   parameter int               BYTE_W        = 8,
   parameter int               CMD_W         = 4,
   parameter logic [BYTE_W-1:0] LOCK_CODE     = 8'h50,
   parameter logic [BYTE_W-1:0] OPEN_CODE_A   = 8'h00,
   parameter logic [BYTE_W-1:0] OPEN_CODE_B   = 8'hFF,
   parameter logic [CMD_W-1:0]  ERASE_ALL_CMD = 4'h3,
   parameter bit               FAIL_SAFE     = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [BYTE_W-1:0] sec_byte_i,
   input  logic              erase_done_i,
   input  logic [1:0]        origin_i,
   input  logic              code_rd_req_i,
   input  logic              cmd_wr_i,
   input  logic [CMD_W-1:0]  cmd_val_i,
   input  logic              par_req_i,
   input  logic [1:0]        par_op_i,
   output logic              code_rd_ok_o,
   output logic              cmd_wr_ok_o,
   output logic              par_ok_o,
   output logic              lock_active_o
);
   initial begin
      assert (LOCK_CODE != OPEN_CODE_A && LOCK_CODE != OPEN_CODE_B)
         else $error("lock code collides with an open code");
      assert (CMD_W >= 1 && CMD_W <= BYTE_W)
         else $error("command width out of range");
   end

   logic code_active;
   logic locked;

   fsec_code_decode #(
      .BYTE_W     (BYTE_W),
      .LOCK_CODE  (LOCK_CODE),
      .OPEN_CODE_A(OPEN_CODE_A),
      .OPEN_CODE_B(OPEN_CODE_B),
      .FAIL_SAFE  (FAIL_SAFE)
   ) u_decode (
      .byte_i  (sec_byte_i),
      .active_o(code_active)
   );

   fsec_lock_reg u_lock (
      .clk          (clk),
      .rst_n        (rst_n),
      .active_code_i(code_active),
      .erase_done_i (erase_done_i),
      .locked_o     (locked)
   );

   fsec_access_gate #(
      .CMD_W        (CMD_W),
      .ERASE_ALL_CMD(ERASE_ALL_CMD)
   ) u_gate (
      .clk          (clk),
      .rst_n        (rst_n),
      .locked_i     (locked),
      .origin_i     (origin_i),
      .code_rd_req_i(code_rd_req_i),
      .cmd_wr_i     (cmd_wr_i),
      .cmd_val_i    (cmd_val_i),
      .par_req_i    (par_req_i),
      .par_op_i     (par_op_i),
      .code_rd_ok_o (code_rd_ok_o),
      .cmd_wr_ok_o  (cmd_wr_ok_o),
      .par_ok_o     (par_ok_o)
   );

   assign lock_active_o = locked;
endmodule

// File: tb/fsec_lock_ctrl_tb.sv
module fsec_lock_ctrl_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] sec_byte = 8'h50;
   logic       erase_done = 1'b0;
   logic [1:0] origin = 2'b00;
   logic       code_rd_req = 1'b0;
   logic       cmd_wr = 1'b0;
   logic [3:0] cmd_val = 4'h0;
   logic       par_req = 1'b0;
   logic [1:0] par_op = 2'b00;
   logic       code_rd_ok, cmd_wr_ok, par_ok, lock_active;

   int  n_chk = 0;
   int  n_bad = 0;
   bit  model_lock;
   bit  finished = 1'b0;

   always #10 clk = ~clk;

   fsec_lock_ctrl u_dut (
      .clk(clk), .rst_n(rst_n), .sec_byte_i(sec_byte), .erase_done_i(erase_done),
      .origin_i(origin), .code_rd_req_i(code_rd_req), .cmd_wr_i(cmd_wr),
      .cmd_val_i(cmd_val), .par_req_i(par_req), .par_op_i(par_op),
      .code_rd_ok_o(code_rd_ok), .cmd_wr_ok_o(cmd_wr_ok), .par_ok_o(par_ok),
      .lock_active_o(lock_active)
   );

   function automatic bit exp_active(input logic [7:0] b);
      return !(b == 8'h00 || b == 8'hFF);
   endfunction
   function automatic bit exp_rd(input bit lk, input bit rq, input logic [1:0] og);
      return rq && (!lk || og == 2'b00 || og == 2'b10);
   endfunction
   function automatic bit exp_cmd(input bit lk, input bit wr, input logic [1:0] og,
                                  input logic [3:0] cv);
      return wr && (!lk || og == 2'b00 || cv == 4'h3);
   endfunction
   function automatic bit exp_par(input bit lk, input bit rq, input logic [1:0] op);
      return rq && (!lk || op == 2'b00 || op == 2'b11);
   endfunction

   task automatic check(input bit got, input bit exp, input string req, input string what);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s %s: got %0b expected %0b", req, what, got, exp);
      end
   endtask

   task automatic do_reset(input logic [7:0] b, input bit erase_at_sample);
      string tag;
      @(negedge clk);
      rst_n = 1'b0; sec_byte = b; erase_done = 1'b0;
      origin = 2'b01; code_rd_req = 1'b1; cmd_wr = 1'b1; cmd_val = 4'h5;
      par_req = 1'b1; par_op = 2'b01;
      repeat (2) @(negedge clk);
      check(lock_active, 1'b1, "R1", "lock in reset");
      check(code_rd_ok, 1'b0, "R1", "ext read in reset");
      check(cmd_wr_ok, 1'b0, "R1", "cmd write in reset");
      rst_n = 1'b1;
      erase_done = erase_at_sample;
      #2;
      check(lock_active, 1'b1, "R1", "lock before sample edge");
      check(par_ok, 1'b0, "R1", "program before sample edge");
      @(posedge clk); #1;
      erase_done = 1'b0;
      model_lock = erase_at_sample ? 1'b0 : exp_active(b);
      @(negedge clk);
      if (erase_at_sample) tag = "R9";
      else if (b == 8'h50 || b == 8'h00 || b == 8'hFF) tag = "R2";
      else tag = "R3";
      check(lock_active, model_lock, tag, $sformatf("lock after sample of %02h", b));
   endtask

   task automatic run_vectors(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         sec_byte    = 8'($urandom);
         origin      = 2'($urandom);
         code_rd_req = 1'($urandom);
         cmd_wr      = 1'($urandom);
         cmd_val     = ($urandom % 4 == 0) ? 4'h3 : 4'($urandom);
         par_req     = 1'($urandom);
         par_op      = 2'($urandom);
         erase_done  = ($urandom % 40 == 0);
         #2;
         check(lock_active, model_lock, "R4", "lock held against byte changes");
         check(code_rd_ok, exp_rd(model_lock, code_rd_req, origin),
               code_rd_req ? "R5" : "R10", "code read grant");
         check(cmd_wr_ok, exp_cmd(model_lock, cmd_wr, origin, cmd_val),
               !cmd_wr ? "R10" : (origin == 2'b00 ? "R6" : "R7"), "command write grant");
         check(par_ok, exp_par(model_lock, par_req, par_op),
               par_req ? "R8" : "R10", "parallel grant");
         @(posedge clk); #1;
         if (erase_done) begin
            model_lock = 1'b0;
            erase_done = 1'b0;
            #2;
            check(lock_active, 1'b0, "R9", "lock after erase done");
         end
      end
   endtask

   initial begin
      void'($urandom(32'd20240517));
      // directed sampling values: arm, open codes, corrupted arm codes
      do_reset(8'h50, 1'b0); run_vectors(40);
      do_reset(8'h00, 1'b0); run_vectors(40);
      do_reset(8'hFF, 1'b0); run_vectors(40);
      do_reset(8'h51, 1'b0); run_vectors(20);
      do_reset(8'hD0, 1'b0); run_vectors(20);
      do_reset(8'h40, 1'b0); run_vectors(20);
      do_reset(8'h10, 1'b0); run_vectors(20);
      do_reset(8'h70, 1'b0); run_vectors(20);
      do_reset(8'h58, 1'b0); run_vectors(20);
      // erase pulse aimed at the sampling edge
      do_reset(8'h50, 1'b1); run_vectors(20);
      // directed gate corners with lock active
      do_reset(8'h50, 1'b0);
      @(negedge clk);
      origin = 2'b10; cmd_wr = 1'b1; cmd_val = 4'h3; code_rd_req = 1'b1;
      par_req = 1'b1; par_op = 2'b11; #2;
      check(cmd_wr_ok, 1'b1, "R7", "boot writes whole-erase command");
      check(code_rd_ok, 1'b1, "R5", "boot read while locked");
      check(par_ok, 1'b1, "R8", "signature read while locked");
      cmd_val = 4'h5; par_op = 2'b10; origin = 2'b11; #2;
      check(cmd_wr_ok, 1'b0, "R7", "reserved origin other command");
      check(code_rd_ok, 1'b0, "R5", "reserved origin read while locked");
      check(par_ok, 1'b0, "R8", "verify while locked");
      // random reset campaign
      for (int r = 0; r < 40; r++) begin
         do_reset(($urandom % 3 == 0) ? (($urandom % 2) ? 8'h00 : 8'hFF) : 8'($urandom),
                  ($urandom % 10 == 0));
         run_vectors(60);
      end
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      #(20 * 150000);
      if (!finished) begin
         n_bad++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end
endmodule